// File: doc/BRIEF.md
# Video Control Signal Pulse Filter

This block conditions the three control lines of a pixel stream (data enable, horizontal sync and vertical sync) before they are packed into a serial link. All three lines are sampled on the pixel clock. A two-bit mode input selects how data enable and horizontal sync are handled. In filter mode, a short glitch on either of those lines is discarded. A new level reaches the output only after it has been seen on a minimum number of consecutive clock edges. In any other mode, both lines are simply registered once.

Vertical sync never passes through the width filter, whatever the mode. Each line also has a limit on how often its output may change. Data enable and horizontal sync may change at most twice in any stretch of 130 clocks, and vertical sync at most once. When an output change breaks this limit, a sticky violation flag is set for that line. The change itself is still forwarded. The flag stays set until the next reset.

Top module: `video_ctl_filter`

## Requirements
- R1: An asynchronous active-low reset drives de_o, hs_o, vs_o and viol_o to zero while it is asserted, and clears all filter history and transition ages.
- R2: With mode_i = 2'b00, de_o and hs_o take the value that de_i and hs_i had at the previous rising clock edge (one register of delay).
- R3: With mode_i = 2'b01, a new level on de_i or hs_i appears on the output after the third consecutive rising edge that samples that level. A pulse sampled on fewer than 3 consecutive edges is dropped, and the output keeps its previous value.
- R4: mode_i = 2'b10 and mode_i = 2'b11 behave exactly like mode_i = 2'b00.
- R5: vs_o always equals vs_i from the previous rising edge, whatever the value of mode_i. A one-clock vertical sync pulse passes even in mode 2'b01.
- R6: viol_o[0] (data enable) or viol_o[1] (horizontal sync) is set when that output changes fewer than 130 clock edges after the output change two changes before it. At exactly 130 edges, no flag is set.
- R7: viol_o[2] (vertical sync) is set when vs_o changes fewer than 130 clock edges after its previous change. At exactly 130 edges, no flag is set.
- R8: Each viol_o bit, once set, stays set until reset.
- R9: A pulse dropped by the width filter does not count toward the transition limit.
- R10: A viol_o bit rises on the same clock edge as the output change that breaks the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 2 | 00 pass, 01 width filter, 10/11 pass |
| de_i | input | 1 | Data enable in |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| de_o | output | 1 | Conditioned data enable |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Registered vertical sync |
| viol_o | output | 3 | Sticky rate violation: bit0 DE, bit1 HS, bit2 VS |

## Verification
In pass-through, a changed input shows at the outputs one edge later. In filter mode, it shows after the third sampling edge, so the bench checks it two and three cycles after the input change, to show it neither arrives early nor late. A violation flag is due on the same edge as the output change that causes it. The bench therefore reads the flag one cycle before and one cycle after that edge. It places the offending change at 129 and at 130 edges from the reference change. Inputs change at the falling edge and every check is made at a later falling edge, so each expected value is fixed by counting rising edges only.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  typedef enum logic [1:0] {
    MODE_PASS   = 2'b00,
    MODE_FILTER = 2'b01,
    MODE_ALT_A  = 2'b10,
    MODE_ALT_B  = 2'b11
  } vcf_mode_e;

  localparam int unsigned CH_DE = 0;
  localparam int unsigned CH_HS = 1;
  localparam int unsigned CH_VS = 2;
  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/vcf_pulse_filter.sv
module vcf_pulse_filter #(
  parameter int unsigned MIN_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic sig_i,
  output logic sig_o,
  output logic accept_o
);
  localparam int unsigned HIST = MIN_WIDTH - 1;

  logic [HIST-1:0] hist_q, hist_d;
  logic [HIST:0]   window;
  logic            out_q, out_d, steady;

  always_comb begin
    window = {hist_q, sig_i};
    hist_d = window[HIST-1:0];
    steady = (&window) | ~(|window);
    if (filt_en) out_d = steady ? sig_i : out_q;
    else         out_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign sig_o    = out_q;
  assign accept_o = (out_d != out_q);

  // R2
  pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> (out_q == $past(sig_i)));

  // R3
  filter_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_en) && (out_q != $past(out_q))) |-> (hist_q == {HIST{out_q}}));

  // R3
  change_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(sig_i) == out_q));
endmodule

// File: rtl/vcf_rate_budget.sv
module vcf_rate_budget #(
  parameter int unsigned WINDOW = 130,
  parameter int unsigned LIMIT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic viol_o
);
  localparam int unsigned AGE_W = $clog2(WINDOW + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WINDOW);

  logic [AGE_W-1:0] age_q [LIMIT];
  logic [AGE_W-1:0] age_d [LIMIT];
  logic             viol_q, viol_d;

  function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
    return (a >= AGE_MAX) ? AGE_MAX : a + AGE_W'(1);
  endfunction

  for (genvar i = 0; i < LIMIT; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign age_d[i] = accept_i ? AGE_W'(1) : sat_inc(age_q[i]);
    end else begin : g_tail
      assign age_d[i] = accept_i ? sat_inc(age_q[i-1]) : sat_inc(age_q[i]);
    end
  end

  always_comb begin
    viol_d = viol_q | (accept_i & (age_q[LIMIT-1] < AGE_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LIMIT; i++) age_q[i] <= AGE_MAX;
      viol_q <= 1'b0;
    end else begin
      for (int i = 0; i < LIMIT; i++) age_q[i] <= age_d[i];
      viol_q <= viol_d;
    end
  end

  assign viol_o = viol_q;

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q);

  // R10
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> $past(accept_i));
endmodule

// File: rtl/video_ctl_filter.sv
module video_ctl_filter
  import vcf_pkg::*;
#(
  parameter int unsigned MIN_WIDTH  = 3,
  parameter int unsigned WINDOW     = 130,
  parameter int unsigned FAST_LIMIT = 2,
  parameter int unsigned SLOW_LIMIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       de_i,
  input  logic       hs_i,
  input  logic       vs_i,
  output logic       de_o,
  output logic       hs_o,
  output logic       vs_o,
  output logic [2:0] viol_o
);
  vcf_mode_e         mode;
  logic              filter_on;
  logic [NUM_CH-1:0] sig_in, sig_out, accept, viol;

  always_comb begin
    mode      = vcf_mode_e'(mode_i);
    filter_on = (mode == MODE_FILTER);
  end

  assign sig_in = {vs_i, hs_i, de_i};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned LIM = (ch == CH_VS) ? SLOW_LIMIT : FAST_LIMIT;
    logic ch_filt;
    assign ch_filt = (ch == CH_VS) ? 1'b0 : filter_on;

    vcf_pulse_filter #(.MIN_WIDTH(MIN_WIDTH)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .filt_en  (ch_filt),
      .sig_i    (sig_in[ch]),
      .sig_o    (sig_out[ch]),
      .accept_o (accept[ch])
    );

    vcf_rate_budget #(.WINDOW(WINDOW), .LIMIT(LIM)) u_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept[ch]),
      .viol_o   (viol[ch])
    );
  end

  assign de_o   = sig_out[CH_DE];
  assign hs_o   = sig_out[CH_HS];
  assign vs_o   = sig_out[CH_VS];
  assign viol_o = viol;

  // R5
  vs_mode_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vs_o == $past(vs_i)));

  // R10
  de_viol_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_o[CH_DE]) |-> (de_o != $past(de_o)));

  // R7
  vs_viol_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_o[CH_VS]) |-> (vs_o != $past(vs_o)));
endmodule

// File: tb/video_ctl_filter_tb.sv
module video_ctl_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       de_i, hs_i, vs_i;
  logic       de_o, hs_o, vs_o;
  logic [2:0] viol_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  video_ctl_filter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .viol_o(viol_o)
  );

  // {mode, de, hs, vs, exp_de, exp_hs, exp_vs}; applied at one falling edge, checked at the next
  localparam int NV = 19;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_100_100, 8'b00_010_010, 8'b00_111_111, 8'b00_001_001,
    8'b01_101_001, 8'b01_100_000, 8'b01_100_100, 8'b01_010_100,
    8'b01_000_100, 8'b01_000_000, 8'b01_011_001, 8'b01_011_001,
    8'b01_001_001, 8'b10_110_110, 8'b11_011_011, 8'b11_000_000,
    8'b01_100_000, 8'b01_100_000, 8'b01_100_100
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; de_i = 0; hs_i = 0; vs_i = 0;
    cyc(3);
    check("R1 reset outputs", {de_o, hs_o, vs_o}, 3'b000);
    check("R1 reset flags", viol_o, 3'b000);
    rst_n = 1'b1;
    cyc(1);

    // vector table: R2 mode 00, R3 mode 01, R4 modes 10/11, R5 vsync in every mode
    {mode_i, de_i, hs_i, vs_i} = VEC[0][7:3];
    for (int i = 0; i < NV; i++) begin
      cyc(1);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), {de_o, hs_o, vs_o}, VEC[i][2:0]);
      if (i + 1 < NV) {mode_i, de_i, hs_i, vs_i} = VEC[i+1][7:3];
    end

    // R1: asynchronous reset with outputs and flags set
    check("R1 precondition de high", {2'b00, de_o}, 3'b001);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear outputs", {de_o, hs_o, vs_o}, 3'b000);
    check("R1 async clear flags", viol_o, 3'b000);
    de_i = 0; hs_i = 0; vs_i = 0; mode_i = 2'b00;
    cyc(2);
    rst_n = 1'b1;

    // R3: exact filter latency
    do_reset(); mode_i = 2'b01;
    de_i = 1;
    cyc(2);
    check("R3 not before third edge", {2'b00, de_o}, 3'b000);
    cyc(1);
    check("R3 at third edge", {2'b00, de_o}, 3'b001);

    // R6 / R10: third change 129 edges after first -> flag
    do_reset(); mode_i = 2'b00;
    de_i = 1; cyc(10);
    de_i = 0; cyc(119);
    check("R10 flag not early", viol_o, 3'b000);
    de_i = 1; cyc(1);
    check("R10 de change visible", {2'b00, de_o}, 3'b001);
    check("R6 de at 129 edges", viol_o, 3'b001);
    cyc(300);
    check("R8 de flag sticky", viol_o, 3'b001);
    do_reset();
    check("R1 flag cleared by reset", viol_o, 3'b000);

    // R6: boundary of exactly 130 edges -> no flag
    mode_i = 2'b00;
    de_i = 1; cyc(10);
    de_i = 0; cyc(120);
    de_i = 1; cyc(1);
    check("R6 de at 130 edges no flag", {viol_o[2:1], de_o}, 3'b001);
    check("R6 de at 130 flag", viol_o, 3'b000);

    // R6: horizontal sync bit position
    do_reset(); mode_i = 2'b00;
    hs_i = 1; cyc(1); hs_i = 0; cyc(1); hs_i = 1; cyc(1);
    check("R6 hs flag bit1", viol_o, 3'b010);

    // R7: vertical sync budget, filter mode selected (ignored)
    do_reset(); mode_i = 2'b01;
    vs_i = 1; cyc(129);
    check("R7 vs no flag yet", viol_o, 3'b000);
    vs_i = 0; cyc(1);
    check("R7 vs change passes", {2'b00, vs_o}, 3'b000);
    check("R7 vs at 129 edges", viol_o, 3'b100);
    do_reset(); mode_i = 2'b01;
    vs_i = 1; cyc(130);
    vs_i = 0; cyc(1);
    check("R7 vs at 130 edges no flag", viol_o, 3'b000);

    // R9: dropped pulses are not counted
    do_reset(); mode_i = 2'b01;
    for (int k = 0; k < 5; k++) begin
      de_i = 1; cyc(2);
      de_i = 0; cyc(2);
    end
    check("R9 dropped pulses keep output", {2'b00, de_o}, 3'b000);
    de_i = 1; cyc(3);
    check("R9 real edge passes", {2'b00, de_o}, 3'b001);
    de_i = 0; cyc(3);
    check("R9 two changes within limit", {viol_o[2:1], de_o}, 3'b000);
    check("R9 no flag from dropped pulses", viol_o, 3'b000);

    finish_run();
  end
endmodule